// File: doc/BRIEF.md
# Fly-by Device-to-Memory Transfer Controller

This block moves a run of words from a peripheral into memory while the processor does other work. Software writes a word-aligned target address, a word count and a control word. The control word holds a go bit and a mode bit. The controller then requests the system bus. Once the bus is granted, it drives the memory address together with a write strobe and a read request to the peripheral. The peripheral puts its data straight onto the memory bus, so the data never passes through the controller. The peripheral's acknowledge ends each word.

After each acknowledge the controller advances the address by one word and takes one from the remaining count. When the count reaches zero it releases the bus and raises a completion interrupt. The interrupt stays high until software clears it. The mode bit selects one of two bus policies. In the single-word policy the controller gives the bus back after every word and asks for it again. In the block policy it keeps the bus until the whole run is done.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: After reset the controller is idle, bus_req, dev_req, mem_we and irq are low, and the address and count registers read 0.
- R2: Register select 0 is the target address, 1 is the remaining word count, 2 is control (bit 0 go, bit 1 block mode), and 3 is status (bit 0 busy, bit 1 interrupt pending). Reads return the live address and count.
- R3: dev_req and mem_we are asserted only while bus_gnt is high, and the first word of a run starts only after a grant.
- R4: For each word, dev_req and mem_we stay high with a steady mem_addr until dev_ack is seen. Exactly one word is counted per acknowledge.
- R5: Each acknowledge raises the address by 4 and lowers the count by 1. A run of N words from base B writes B, B+4, ..., B+4(N-1).
- R6: When the last word is acknowledged, the controller drops bus_req and clears busy, the count reads 0, and the address reads B+4N.
- R7: With the mode bit at 0, bus_req falls for at least one cycle after every word, so a run of N words makes N separate bus requests.
- R8: With the mode bit at 1, bus_req stays high from the first request to the last acknowledge, so a run makes one bus request.
- R9: irq goes high when a run finishes and stays high until a write to status with bit 1 set. A status write with bit 1 clear leaves it high.
- R10: While busy, writes to the address, count and control registers are ignored. The run in progress keeps its word count and its address sequence.
- R11: Setting go with a count of 0 raises irq at once, without a bus request or memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Completion interrupt, sticky |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| dev_req | output | 1 | Read request to the peripheral |
| dev_ack | input | 1 | Peripheral acknowledge, one cycle per word |
| mem_we | output | 1 | Memory write strobe for fly-by data |
| mem_addr | output | ADDR_W | Memory word address |

## Verification
The grant and step assertions rely on three things about the inputs. The arbiter keeps bus_gnt high for as long as bus_req stays high. The peripheral pulses dev_ack for one cycle and only while dev_req is high. The base address is word-aligned. The bench's arbiter and peripheral models work within these limits. Each grants or acknowledges after a random delay of zero to two cycles, withdraws the grant only after the request falls, and clears the acknowledge on the next cycle. The random runs use aligned bases and counts of one to eight words.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int unsigned REG_W = 32;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARB  = 2'd1,
        S_MOVE = 2'd2,
        S_GAP  = 2'd3
    } eng_state_t;

    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_t;

    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_BURST_BIT = 1;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_IRQ_BIT   = 1;

    typedef struct packed {
        logic ld_addr;
        logic ld_count;
        logic go;
        logic burst;
    } cmd_t;

    function automatic logic sel_is(input logic [1:0] sel, input reg_sel_t which);
        return sel == 2'(which);
    endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  cur_count,
    output cmd_t              cmd,
    output logic              irq
);
    logic mode_q;
    logic wr_ok;
    logic irq_clr;

    assign wr_ok   = cfg_wr && !busy;
    assign irq_clr = cfg_wr && sel_is(cfg_sel, SEL_STAT) && cfg_wdata[STAT_IRQ_BIT];

    always_comb begin
        cmd.ld_addr  = wr_ok && sel_is(cfg_sel, SEL_ADDR);
        cmd.ld_count = wr_ok && sel_is(cfg_sel, SEL_COUNT);
        cmd.go       = wr_ok && sel_is(cfg_sel, SEL_CTRL) && cfg_wdata[CTRL_GO_BIT];
        cmd.burst    = cfg_wdata[CTRL_BURST_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (wr_ok && sel_is(cfg_sel, SEL_CTRL))
                mode_q <= cfg_wdata[CTRL_BURST_BIT];
            if (done)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_sel)
            2'(SEL_ADDR):  cfg_rdata = REG_W'(cur_addr);
            2'(SEL_COUNT): cfg_rdata = REG_W'(cur_count);
            2'(SEL_CTRL):  cfg_rdata[CTRL_BURST_BIT] = mode_q;
            default: begin
                cfg_rdata[STAT_BUSY_BIT] = busy;
                cfg_rdata[STAT_IRQ_BIT]  = irq;
            end
        endcase
    end

    // R9: a finished run always leaves the interrupt pending
    assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> irq);
    // R9: the pending interrupt survives until an explicit clear
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [REG_W-1:0]  wdata,
    input  logic              bus_gnt,
    input  logic              dev_ack,
    output logic              bus_req,
    output logic              dev_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    eng_state_t        state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              burst_q;
    logic              last_word;
    logic              word_done;

    assign last_word = (cnt_q == ONE);
    assign word_done = (state == S_MOVE) && dev_ack;

    always_comb begin
        nxt  = state;
        done = 1'b0;
        unique case (state)
            S_IDLE: if (cmd.go) begin
                if (cnt_q == '0) done = 1'b1;
                else             nxt  = S_ARB;
            end
            S_ARB:  if (bus_gnt) nxt = S_MOVE;
            S_MOVE: if (dev_ack) begin
                if (last_word) begin
                    done = 1'b1;
                    nxt  = S_IDLE;
                end else if (!burst_q) begin
                    nxt = S_GAP;
                end
            end
            default: nxt = S_ARB;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            burst_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE) begin
                if (cmd.ld_addr)  addr_q  <= wdata[ADDR_W-1:0];
                if (cmd.ld_count) cnt_q   <= wdata[CNT_W-1:0];
                if (cmd.go)       burst_q <= cmd.burst;
            end
            if (word_done) begin
                addr_q <= addr_q + STEP;
                cnt_q  <= cnt_q - ONE;
            end
        end
    end

    assign bus_req   = (state == S_ARB) || (state == S_MOVE);
    assign dev_req   = (state == S_MOVE);
    assign mem_we    = (state == S_MOVE);
    assign mem_addr  = addr_q;
    assign cur_addr  = addr_q;
    assign cur_count = cnt_q;
    assign busy      = (state != S_IDLE);

    // R3: no fly-by word while the bus is not ours
    assert_grant_R3: assert property (@(posedge clk) disable iff (rst)
        dev_req |-> bus_gnt);
    // R4: a pending word keeps its address until acknowledged
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (dev_req && !dev_ack) |=> (dev_req && $stable(mem_addr)));
    // R5: one word step per acknowledge
    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        word_done |=> (cur_addr == $past(cur_addr) + STEP && cur_count == $past(cur_count) - ONE));
    // R6: finishing releases the bus
    assert_release_R6: assert property (@(posedge clk) disable iff (rst)
        (word_done && last_word) |=> (!bus_req && !busy));
    // R7: single-word policy gives the bus back after each word
    assert_steal_R7: assert property (@(posedge clk) disable iff (rst)
        (word_done && !burst_q) |=> !bus_req);
    // R8: block policy keeps the bus between words
    assert_burst_R8: assert property (@(posedge clk) disable iff (rst)
        (word_done && burst_q && !last_word) |=> (bus_req && dev_req));
endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              dev_req,
    input  logic              dev_ack,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);
    cmd_t              cmd;
    logic              busy;
    logic              done;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_count;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .done      (done),
        .cur_addr  (cur_addr),
        .cur_count (cur_count),
        .cmd       (cmd),
        .irq       (irq)
    );

    dma_xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wdata     (cfg_wdata),
        .bus_gnt   (bus_gnt),
        .dev_ack   (dev_ack),
        .bus_req   (bus_req),
        .dev_req   (dev_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .cur_addr  (cur_addr),
        .cur_count (cur_count),
        .busy      (busy),
        .done      (done)
    );
endmodule

// File: tb/sim_dma_flyby_ctrl.sv
`timescale 1ns/1ps
module sim_dma_flyby_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic        bus_req;
    logic        bus_gnt;
    logic        dev_req;
    logic        dev_ack;
    logic        mem_we;
    logic [31:0] mem_addr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int words_seen, addr_errs, req_rises, nogrant_errs;
    logic [31:0] exp_base;
    logic prev_req;
    int gdly, adly;

    always #4 clk = ~clk;

    dma_flyby_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .dev_req(dev_req),
        .dev_ack(dev_ack), .mem_we(mem_we), .mem_addr(mem_addr)
    );

    function automatic logic [31:0] exp_word_addr(logic [31:0] base, int idx);
        return base + 32'(4 * idx);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // arbiter and peripheral models, driven away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            bus_gnt = 0; dev_ack = 0; prev_req = 0; gdly = 0; adly = 0;
        end else begin
            if (bus_req && !prev_req) req_rises++;
            prev_req = bus_req;
            if ((dev_req || mem_we) && !bus_gnt) nogrant_errs++;
            if (bus_req && !bus_gnt) begin
                if (gdly == 0) bus_gnt = 1; else gdly--;
            end else if (!bus_req) begin
                bus_gnt = 0; gdly = $urandom % 3;
            end
            if (dev_req && !dev_ack) begin
                if (adly == 0) begin
                    dev_ack = 1;
                    if (mem_addr !== exp_word_addr(exp_base, words_seen)) addr_errs++;
                    words_seen++;
                    adly = $urandom % 3;
                end else adly--;
            end else dev_ack = 0;
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic rd(logic [1:0] sel, output logic [31:0] d);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(logic [31:0] base, int n, logic burst);
        logic [31:0] v;
        exp_base = base; words_seen = 0; addr_errs = 0; req_rises = 0; nogrant_errs = 0;
        wr(2'd0, base);
        wr(2'd1, 32'(n));
        wr(2'd2, {30'd0, burst, 1'b1});
        wait_irq();
        check("R4 words", 32'(words_seen), 32'(n));
        check("R5 addr seq errs", 32'(addr_errs), 0);
        check("R3 no-grant", 32'(nogrant_errs), 0);
        check(burst ? "R8 requests" : "R7 requests", 32'(req_rises), burst ? 1 : 32'(n));
        rd(2'd0, v); check("R6 final addr", v, exp_word_addr(base, n));
        rd(2'd1, v); check("R6 final count", v, 0);
        rd(2'd3, v); check("R6 status", v, 32'h2);
        check("R6 bus_req", {31'd0, bus_req}, 0);
        wr(2'd3, 32'h2);
        check("R9 cleared", {31'd0, irq}, 0);
    endtask

    initial begin
        logic [31:0] v;
        cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0; exp_base = 0;
        words_seen = 0; addr_errs = 0; req_rises = 0; nogrant_errs = 0;
        void'($urandom(32'd1234));
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 bus_req", {31'd0, bus_req}, 0);
        check("R1 dev_req", {31'd0, dev_req | mem_we}, 0);
        rd(2'd0, v); check("R1 addr", v, 0);
        rd(2'd1, v); check("R1 count", v, 0);
        rd(2'd3, v); check("R1 status", v, 0);
        // R2 register readback
        wr(2'd0, 32'h0000_1000); rd(2'd0, v); check("R2 addr", v, 32'h1000);
        wr(2'd1, 32'd7);         rd(2'd1, v); check("R2 count", v, 7);
        // directed runs
        run(32'h0000_2000, 1, 1'b0);
        run(32'h0000_3000, 5, 1'b1);
        run(32'h0000_4000, 4, 1'b0);
        // R11 zero count
        req_rises = 0; words_seen = 0;
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h1);
        check("R11 irq", {31'd0, irq}, 1);
        repeat (3) @(negedge clk);
        check("R11 no request", 32'(req_rises), 0);
        check("R11 no write", 32'(words_seen), 0);
        // R9: write with bit 1 clear keeps irq
        wr(2'd3, 32'h0);
        check("R9 kept", {31'd0, irq}, 1);
        wr(2'd3, 32'h2);
        check("R9 clear", {31'd0, irq}, 0);
        // R10 writes while busy are ignored
        exp_base = 32'h0000_5000; words_seen = 0; addr_errs = 0;
        wr(2'd0, 32'h0000_5000);
        wr(2'd1, 32'd6);
        wr(2'd2, 32'h3);
        rd(2'd3, v); check("R10 busy", v & 32'h1, 1);
        wr(2'd0, 32'hDEAD_0000);
        wr(2'd1, 32'd99);
        wr(2'd2, 32'h1);
        wait_irq();
        check("R10 words", 32'(words_seen), 6);
        check("R10 addr seq", 32'(addr_errs), 0);
        rd(2'd0, v); check("R10 final addr", v, 32'h0000_5018);
        wr(2'd3, 32'h2);
        // random runs
        for (int i = 0; i < 8; i++) begin
            logic [31:0] b;
            int n;
            b = {$urandom % 32'h10000, 2'b00};
            n = 1 + ($urandom % 8);
            run(b, n, 1'($urandom % 2));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule